// File: doc/BRIEF.md
# Programmable-Phase Peripheral Access Sequencer

This block turns single host read and write requests into strobe sequences for a slow external peripheral. Each access has three timed phases: address setup, strobe active and recovery. Chip select is held through all three. The read or write strobe is asserted only in the middle phase. Each phase length comes from a configuration word. The strobe phase has one length for reads and a separate length for writes. The host sees a one-cycle acknowledge when the access is complete, and for reads the captured data is on `rdata_o` at that point.

The data path handles byte or 16-bit halfword transfers and can exchange the two byte lanes. It drives even parity per byte lane on writes. When parity checking is enabled, it checks per-lane parity on reads and reports a parity mismatch through an error flag and an interrupt pulse. The configuration, address and write data are captured when a request is accepted, so the host may change them while an access is running. `req_i` is sampled only while the sequencer is idle.

Top module: `pio_seq`

## Requirements
- R1: After reset, `cs_o`, `rd_o`, `wr_o`, `pd_oe_o`, `ack_o`, `irq_o` and `perr_o` are all low.
- R2: The configuration word `cfg_i` has these fields:
  - [2:0] setup length
  - [6:3] read strobe length
  - [9:7] write strobe length
  - [11:10] recovery length
  - [12] halfword enable
  - [13] lane swap
  - [14] parity check enable

  `cs_o` is high for setup + strobe + recovery cycles. The ack cycle is the last of these.
- R3: A phase field of zero lasts one cycle, so every access keeps `cs_o` high for at least three cycles.
- R4: The strobe phase asserts `rd_o` (read) or `wr_o` (write) for the read length (4-bit field) or the write length (3-bit field). The other strobe stays low.
- R5: `ack_o` is high for exactly one cycle, in the last recovery cycle. `rdata_o` holds the read result from that cycle until the next read completes.
- R6: A request is accepted only while idle. `cs_o` is low in the cycle after `ack_o`, even with `req_i` held high. The configuration, address and write data are captured at acceptance, and later changes to these inputs do not affect the running access.
- R7: Byte mode uses only byte lane 0 (bits 7:0):
  - A write drives `wdata_i[7:0]` on lane 0 and zero on lane 1.
  - A read returns lane 0 zero-extended.

  Halfword mode moves all 16 bits.
- R8: With lane swap set, bits 15:8 and 7:0 are exchanged on both reads and writes. In byte mode this moves the active lane to bits 15:8.
- R9: During a write access `pd_oe_o` is high. `pp_o[i]` is the even parity (XOR) of byte lane i of `pd_o`.
- R10: With parity check enabled, a read whose active lane has `pp_i[i]` different from the XOR of that lane sets `perr_o` and pulses `irq_o` with `ack_o`. `perr_o` holds until the next accepted request. Inactive lanes, writes, and reads with checking disabled never set it.
- R11: `rd_o` and `wr_o` are never high together, neither is high without `cs_o`, and `pa_o` is stable while `cs_o` stays high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_i | input | 15 | Phase lengths and data-path mode bits |
| req_i | input | 1 | Host access request |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | ADDR_W | Peripheral address |
| wdata_i | input | 16 | Host write data |
| ack_o | output | 1 | One-cycle completion pulse |
| rdata_o | output | 16 | Read result |
| perr_o | output | 1 | Parity error on the last read |
| irq_o | output | 1 | Parity error interrupt pulse |
| cs_o | output | 1 | Peripheral chip select |
| rd_o | output | 1 | Read strobe |
| wr_o | output | 1 | Write strobe |
| pa_o | output | ADDR_W | Peripheral address bus |
| pd_o | output | 16 | Peripheral write data bus |
| pd_oe_o | output | 1 | Data bus output enable |
| pp_o | output | 2 | Write parity per byte lane |
| pd_i | input | 16 | Peripheral read data bus |
| pp_i | input | 2 | Read parity per byte lane |

## Verification
The assertions check these rules on every cycle:
- Strobe exclusivity and gating by chip select.
- Address stability during an access.
- The single-cycle acknowledge and the three-cycle minimum access length.
- The phase ordering into idle.
- That a completed write never reports a parity error.

Only the scenarios can show the timing and data results:
- The exact phase durations for each field value, including zero and maximum fields.
- Lane placement under byte, halfword and swap modes, and the generated parity.
- Which lanes take part in the parity check.
- That inputs changed mid-access are ignored.

// File: rtl/pio_seq_pkg.sv
package pio_seq_pkg;
  localparam int BYTE_W  = 8;
  localparam int LANES   = 2;
  localparam int DATA_W  = BYTE_W * LANES;
  localparam int SETUP_W = 3;
  localparam int RSTB_W  = 4;
  localparam int WSTB_W  = 3;
  localparam int RCV_W   = 2;
  localparam int CNT_W   = RSTB_W;

  typedef struct packed {
    logic              par_en;
    logic              swap;
    logic              half;
    logic [RCV_W-1:0]  rcv;
    logic [WSTB_W-1:0] wstb;
    logic [RSTB_W-1:0] rstb;
    logic [SETUP_W-1:0] setup;
  } cfg_t;

  localparam int CFG_W = $bits(cfg_t);

  typedef enum logic [1:0] {PH_IDLE, PH_SETUP, PH_STROBE, PH_RECOV} phase_e;

  function automatic logic [DATA_W-1:0] lane_xchg(input logic [DATA_W-1:0] d,
                                                   input logic en);
    logic [DATA_W-1:0] r;
    r = d;
    if (en)
      for (int i = 0; i < LANES; i++)
        r[i*BYTE_W +: BYTE_W] = d[(LANES-1-i)*BYTE_W +: BYTE_W];
    return r;
  endfunction
endpackage

// File: rtl/pio_phase_timer.sv
module pio_phase_timer
  import pio_seq_pkg::*;
#(
  parameter int CW = CNT_W
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic [CW-1:0] setup_len_i,
  input  logic [CW-1:0] strobe_len_i,
  input  logic [CW-1:0] recov_len_i,
  output phase_e        phase_o,
  output logic          last_o
);
  phase_e        phase_q;
  logic [CW-1:0] cnt_q;
  logic [CW-1:0] cur_len;

  always_comb begin
    case (phase_q)
      PH_SETUP:  cur_len = setup_len_i;
      PH_STROBE: cur_len = strobe_len_i;
      PH_RECOV:  cur_len = recov_len_i;
      default:   cur_len = '0;
    endcase
  end

  // zero-length field still occupies one cycle
  assign last_o  = (phase_q != PH_IDLE) &&
                   ({1'b0, cnt_q} + (CW+1)'(1) >= {1'b0, cur_len});
  assign phase_o = phase_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q <= PH_IDLE;
      cnt_q   <= '0;
    end else begin
      case (phase_q)
        PH_IDLE: begin
          cnt_q <= '0;
          if (start_i) phase_q <= PH_SETUP;
        end
        PH_SETUP: begin
          cnt_q <= last_o ? '0 : cnt_q + CW'(1);
          if (last_o) phase_q <= PH_STROBE;
        end
        PH_STROBE: begin
          cnt_q <= last_o ? '0 : cnt_q + CW'(1);
          if (last_o) phase_q <= PH_RECOV;
        end
        default: begin
          cnt_q <= last_o ? '0 : cnt_q + CW'(1);
          if (last_o) phase_q <= PH_IDLE;
        end
      endcase
    end
  end

  p_recov_exit_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase_q == PH_RECOV && last_o) |=> phase_q == PH_IDLE);
  p_idle_hold_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase_q == PH_IDLE && !start_i) |=> phase_q == PH_IDLE);
  p_setup_first_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase_q == PH_IDLE && start_i) |=> phase_q == PH_SETUP);
endmodule

// File: rtl/pio_wr_lane.sv
module pio_wr_lane
  import pio_seq_pkg::*;
(
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              half_i,
  input  logic              swap_i,
  output logic [DATA_W-1:0] bus_o,
  output logic [LANES-1:0]  par_o
);
  logic [DATA_W-1:0] sized;

  always_comb begin
    sized = half_i ? wdata_i : {{(DATA_W-BYTE_W){1'b0}}, wdata_i[BYTE_W-1:0]};
    bus_o = lane_xchg(sized, swap_i);
  end

  for (genvar g = 0; g < LANES; g++) begin : g_par
    assign par_o[g] = ^bus_o[g*BYTE_W +: BYTE_W];
  end
endmodule

// File: rtl/pio_rd_path.sv
module pio_rd_path
  import pio_seq_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clr_i,
  input  logic              cap_i,
  input  logic [DATA_W-1:0] pd_i,
  input  logic [LANES-1:0]  pp_i,
  input  logic              half_i,
  input  logic              swap_i,
  input  logic              par_en_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              perr_o
);
  logic [DATA_W-1:0] xd;
  logic [LANES-1:0]  active, bad;

  assign xd = lane_xchg(pd_i, swap_i);

  for (genvar g = 0; g < LANES; g++) begin : g_chk
    // byte mode lands on lane 0, or the top lane when swapped
    assign active[g] = half_i || (g == (swap_i ? LANES-1 : 0));
    assign bad[g]    = active[g] && (pp_i[g] != ^pd_i[g*BYTE_W +: BYTE_W]);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rdata_o <= '0;
      perr_o  <= 1'b0;
    end else if (clr_i) begin
      perr_o  <= 1'b0;
    end else if (cap_i) begin
      rdata_o <= half_i ? xd : {{(DATA_W-BYTE_W){1'b0}}, xd[BYTE_W-1:0]};
      perr_o  <= par_en_i && (|bad);
    end
  end

  p_err_needs_en_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(perr_o) |-> $past(par_en_i && cap_i));
endmodule

// File: rtl/pio_seq.sv
module pio_seq
  import pio_seq_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [CFG_W-1:0]  cfg_i,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic              ack_o,
  output logic [DATA_W-1:0] rdata_o,
  output logic              perr_o,
  output logic              irq_o,
  output logic              cs_o,
  output logic              rd_o,
  output logic              wr_o,
  output logic [ADDR_W-1:0] pa_o,
  output logic [DATA_W-1:0] pd_o,
  output logic              pd_oe_o,
  output logic [LANES-1:0]  pp_o,
  input  logic [DATA_W-1:0] pd_i,
  input  logic [LANES-1:0]  pp_i
);
  cfg_t              cfg_q;
  logic              we_q;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] wdata_q;
  phase_e            phase;
  logic              last, start;

  assign start = req_i && (phase == PH_IDLE);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cfg_q   <= '0;
      we_q    <= 1'b0;
      addr_q  <= '0;
      wdata_q <= '0;
    end else if (start) begin
      cfg_q   <= cfg_t'(cfg_i);
      we_q    <= we_i;
      addr_q  <= addr_i;
      wdata_q <= wdata_i;
    end
  end

  pio_phase_timer #(.CW(CNT_W)) u_timer (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .start_i     (start),
    .setup_len_i (CNT_W'(cfg_q.setup)),
    .strobe_len_i(we_q ? CNT_W'(cfg_q.wstb) : CNT_W'(cfg_q.rstb)),
    .recov_len_i (CNT_W'(cfg_q.rcv)),
    .phase_o     (phase),
    .last_o      (last)
  );

  pio_wr_lane u_wr (
    .wdata_i(wdata_q),
    .half_i (cfg_q.half),
    .swap_i (cfg_q.swap),
    .bus_o  (pd_o),
    .par_o  (pp_o)
  );

  pio_rd_path u_rd (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .clr_i   (start),
    .cap_i   (phase == PH_STROBE && last && !we_q),
    .pd_i    (pd_i),
    .pp_i    (pp_i),
    .half_i  (cfg_q.half),
    .swap_i  (cfg_q.swap),
    .par_en_i(cfg_q.par_en),
    .rdata_o (rdata_o),
    .perr_o  (perr_o)
  );

  assign cs_o    = (phase != PH_IDLE);
  assign rd_o    = (phase == PH_STROBE) && !we_q;
  assign wr_o    = (phase == PH_STROBE) && we_q;
  assign pd_oe_o = cs_o && we_q;
  assign pa_o    = addr_q;
  assign ack_o   = (phase == PH_RECOV) && last;
  assign irq_o   = ack_o && perr_o;

  p_strobe_excl_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(rd_o && wr_o));
  p_strobe_in_cs_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_o || wr_o) |-> cs_o);
  p_addr_hold_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cs_o && $past(cs_o)) |-> $stable(pa_o));
  p_ack_pulse_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ack_o |=> !ack_o && !cs_o);
  p_min_len_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ack_o |-> (cs_o && $past(cs_o) && $past(cs_o, 2)));
  p_wr_oe_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_o |-> pd_oe_o);
  p_wr_no_err_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ack_o && pd_oe_o) |-> !perr_o);
endmodule

// File: tb/pio_seq_tb.sv
`timescale 1ns/1ps
module pio_seq_tb;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [14:0] cfg_i = '0;
  logic        req_i = 1'b0, we_i = 1'b0;
  logic [7:0]  addr_i = '0;
  logic [15:0] wdata_i = '0;
  logic        ack_o, perr_o, irq_o, cs_o, rd_o, wr_o, pd_oe_o;
  logic [15:0] rdata_o, pd_o;
  logic [7:0]  pa_o;
  logic [1:0]  pp_o;
  logic [15:0] pd_i = '0;
  logic [1:0]  pp_i = '0;

  always #2.5 clk_i = ~clk_i;

  pio_seq #(.ADDR_W(8)) u_dut (
    .clk_i, .rst_ni, .cfg_i, .req_i, .we_i, .addr_i, .wdata_i,
    .ack_o, .rdata_o, .perr_o, .irq_o, .cs_o, .rd_o, .wr_o, .pa_o,
    .pd_o, .pd_oe_o, .pp_o, .pd_i, .pp_i
  );

  typedef struct {
    bit          we;
    int          cyc;
    int          stb;
    logic [15:0] data;
    logic [1:0]  par;
    bit          err;
    logic [7:0]  addr;
    string       tag;
  } item_t;

  item_t sb[$];
  int checks = 0, errors = 0;

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  function automatic int plen(input int v);
    return (v == 0) ? 1 : v;
  endfunction

  function automatic logic [15:0] xchg(input logic [15:0] d, input bit en);
    return en ? {d[7:0], d[15:8]} : d;
  endfunction

  function automatic logic [1:0] gpar(input logic [15:0] d);
    return {^d[15:8], ^d[7:0]};
  endfunction

  task automatic acc(input bit we, input logic [7:0] addr, input logic [15:0] wd,
                     input int s, input int r, input int w, input int rc,
                     input bit half, input bit swap, input bit pe,
                     input logic [15:0] bus_in, input logic [1:0] par_in,
                     input bit keep, input bit scr, input string tag);
    item_t it;
    logic [14:0] cfg;
    logic [15:0] d;
    bit a0, a1, b0, b1;
    cfg = {pe, swap, half, 2'(rc), 3'(w), 4'(r), 3'(s)};
    it.we = we; it.addr = addr; it.tag = tag;
    it.stb = plen(we ? w : r);
    it.cyc = plen(s) + it.stb + plen(rc);
    if (we) begin
      d = half ? wd : {8'h00, wd[7:0]};
      it.data = xchg(d, swap);
      it.par = gpar(it.data);
      it.err = 1'b0;
    end else begin
      d = xchg(bus_in, swap);
      it.data = half ? d : {8'h00, d[7:0]};
      it.par = '0;
      a0 = half || !swap; a1 = half || swap;
      b0 = par_in[0] != ^bus_in[7:0];
      b1 = par_in[1] != ^bus_in[15:8];
      it.err = pe && ((a0 && b0) || (a1 && b1));
    end
    sb.push_back(it);
    @(negedge clk_i);
    cfg_i = cfg; we_i = we; addr_i = addr; wdata_i = wd;
    pd_i = bus_in; pp_i = par_in; req_i = 1'b1;
    if (scr) begin
      @(negedge clk_i);
      cfg_i = ~cfg; we_i = ~we; addr_i = ~addr; wdata_i = ~wd;
    end
    while (!ack_o) @(negedge clk_i);
    if (!keep) req_i = 1'b0;
  endtask

  // monitor / scoreboard
  initial begin
    int cyc_n = 0, rd_n = 0, wr_n = 0;
    logic [15:0] cap_d = '0;
    logic [1:0]  cap_p = '0;
    bit cap_oe = 0, after_ack = 0, last_err = 0, bad_stb = 0;
    item_t it;
    forever begin
      @(negedge clk_i);
      if (rst_ni) begin
        if (after_ack) begin
          chk(!cs_o, "R6", "cs in cycle after ack", 32'(cs_o), 0);
          chk(!ack_o, "R5", "ack width", 32'(ack_o), 0);
          chk(perr_o == last_err, "R10", "perr held", 32'(perr_o), 32'(last_err));
          after_ack = 0;
        end
        if ((rd_o && wr_o) || ((rd_o || wr_o) && !cs_o)) bad_stb = 1;
        if (cs_o) cyc_n++;
        if (rd_o) rd_n++;
        if (wr_o) begin wr_n++; cap_d = pd_o; cap_p = pp_o; cap_oe = pd_oe_o; end
        if (ack_o) begin
          if (sb.size() == 0) chk(0, "R5", "unexpected ack", 1, 0);
          else begin
            it = sb.pop_front();
            chk(cyc_n == it.cyc, it.tag, "access cycles (R2)", 32'(cyc_n), 32'(it.cyc));
            chk(pa_o == it.addr, "R6", "address", 32'(pa_o), 32'(it.addr));
            chk(!bad_stb, "R11", "strobe gating", 32'(bad_stb), 0);
            if (it.we) begin
              chk(wr_n == it.stb && rd_n == 0, "R4", "write strobe cycles",
                  32'(wr_n), 32'(it.stb));
              chk(cap_d == it.data, it.tag, "write bus (R7)", 32'(cap_d), 32'(it.data));
              chk(cap_p == it.par, "R9", "write parity", 32'(cap_p), 32'(it.par));
              chk(cap_oe, "R9", "output enable", 32'(cap_oe), 1);
            end else begin
              chk(rd_n == it.stb && wr_n == 0, "R4", "read strobe cycles",
                  32'(rd_n), 32'(it.stb));
              chk(rdata_o == it.data, it.tag, "read data (R5)", 32'(rdata_o), 32'(it.data));
            end
            chk(perr_o == it.err, "R10", "parity flag", 32'(perr_o), 32'(it.err));
            chk(irq_o == it.err, "R10", "irq pulse", 32'(irq_o), 32'(it.err));
          end
          last_err = perr_o; after_ack = 1;
          cyc_n = 0; rd_n = 0; wr_n = 0; bad_stb = 0;
        end
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk_i);
    chk(0, "R5", "watchdog expired", 0, 1);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk_i);
    chk({cs_o, rd_o, wr_o, pd_oe_o, ack_o, irq_o, perr_o} == '0, "R1",
        "outputs in reset", 32'({cs_o, rd_o, wr_o, pd_oe_o, ack_o, irq_o, perr_o}), 0);
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk({cs_o, ack_o} == '0, "R1", "idle after reset", 32'({cs_o, ack_o}), 0);
    // byte mode read/write, mixed lengths
    acc(0, 8'h11, 16'h0, 2, 5, 1, 1, 0, 0, 0, 16'hA55A, 2'b00, 0, 0, "R7");
    acc(1, 8'h12, 16'h1234, 2, 5, 1, 1, 0, 0, 0, 16'h0, 2'b00, 0, 0, "R7");
    // all-zero fields
    acc(0, 8'h13, 16'h0, 0, 0, 0, 0, 0, 0, 0, 16'h00C3, 2'b00, 0, 0, "R3");
    acc(1, 8'h14, 16'h00F1, 0, 0, 0, 0, 0, 0, 0, 16'h0, 2'b00, 0, 0, "R3");
    // maximum fields
    acc(0, 8'h15, 16'h0, 7, 15, 7, 3, 1, 0, 0, 16'h5AA5, 2'b00, 0, 0, "R2");
    acc(1, 8'h16, 16'h9876, 7, 15, 7, 3, 1, 0, 0, 16'h0, 2'b00, 0, 0, "R2");
    // halfword, lane swap
    acc(0, 8'h17, 16'h0, 1, 2, 3, 1, 1, 1, 0, 16'hBEEF, 2'b00, 0, 0, "R8");
    acc(1, 8'h18, 16'hCAFE, 1, 2, 3, 1, 1, 1, 0, 16'h0, 2'b00, 0, 0, "R8");
    // byte mode with swap
    acc(0, 8'h19, 16'h0, 1, 3, 2, 2, 0, 1, 0, 16'h7711, 2'b00, 0, 0, "R8");
    acc(1, 8'h1A, 16'h55AB, 1, 3, 2, 2, 0, 1, 0, 16'h0, 2'b00, 0, 0, "R8");
    // parity: good, bad high lane, bad inactive lane, disabled
    acc(0, 8'h21, 16'h0, 1, 2, 1, 1, 1, 0, 1, 16'h1307, gpar(16'h1307), 0, 0, "R10");
    acc(0, 8'h22, 16'h0, 1, 2, 1, 1, 1, 0, 1, 16'h1307, gpar(16'h1307) ^ 2'b10, 0, 0, "R10");
    acc(1, 8'h23, 16'h4242, 1, 1, 1, 1, 1, 0, 1, 16'h0, 2'b00, 0, 0, "R10");
    acc(0, 8'h24, 16'h0, 1, 2, 1, 1, 0, 0, 1, 16'h1307, gpar(16'h1307) ^ 2'b10, 0, 0, "R10");
    acc(0, 8'h25, 16'h0, 1, 2, 1, 1, 0, 1, 1, 16'h1307, gpar(16'h1307) ^ 2'b10, 0, 0, "R10");
    acc(0, 8'h26, 16'h0, 1, 2, 1, 1, 1, 0, 0, 16'h1307, 2'b11 ^ gpar(16'h1307), 0, 0, "R10");
    // request held high and inputs scrambled mid-access
    acc(0, 8'h31, 16'h0, 3, 4, 2, 2, 1, 0, 0, 16'h6C39, 2'b00, 1, 1, "R6");
    acc(1, 8'h32, 16'hD00D, 3, 4, 2, 2, 1, 0, 0, 16'h0, 2'b00, 1, 1, "R6");
    acc(0, 8'h33, 16'h0, 2, 1, 1, 1, 0, 0, 0, 16'h00E4, 2'b00, 0, 0, "R6");
    repeat (4) @(negedge clk_i);
    chk(sb.size() == 0, "R5", "every access acknowledged", 32'(sb.size()), 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule